// File: doc/BRIEF.md
# Status byte aggregator

This block sits at the top of a status reporting tree. It collects one-bit summaries from the status groups below it, together with an error-queue-not-empty flag and a message-available flag, and assembles them into an 8-bit status byte. From that byte, masked by a service-request enable, it derives a master summary bit and a registered service request line.

The block holds the whole tree. It has a standard event register that latches event pulses, an operation group and a questionable group that both detect transitions on condition inputs, and a 16-channel limits-failure group whose summary acts as one condition bit of the questionable group. Each edge-detecting group has a positive filter, a negative filter, a latched event register and an enable. A group's summary is the OR of its event bits ANDed with its enable bits.

Enables and filters are loaded through a small write port. A clear-status pulse empties every event register in the tree.

Top module: `stat_byte_top`

## Requirements
- R1: Status byte bits 0 and 1 are always 0.
- R2: Status byte bit 2 follows `errq_nonempty` and bit 4 follows `msg_avail`, one clock later and without latching.
- R3: The standard event register latches a 1 in each of bits 0, 2, 3, 4, 5 and 7 when the matching `std_evt` pulse bit is high. `std_evt` bits 1 and 6 are ignored. Status byte bit 5 is the OR of the standard event bits ANDed with the standard enable.
- R4: After reset, the standard event register holds only bit 7 (power-on). Every other event register is 0, every enable (including the service-request enable) is 0, every positive filter is all ones and every negative filter is 0.
- R5: In an edge-detecting group, a 0-to-1 change of a condition bit sets the event bit when the matching positive filter bit is 1. A 1-to-0 change sets it when the matching negative filter bit is 1.
- R6: An event bit stays set until a clear-status pulse. An event that arrives in the same cycle as the clear survives it.
- R7: The operation group uses only condition bits 0, 1 and 4; its other bits stay 0. Its summary is status byte bit 7.
- R8: The questionable group takes condition bits 0, 2 and 3 from `ques_cond`; its bit 1 is the limits group summary, and `ques_cond` bit 1 is ignored. Its summary is status byte bit 3.
- R9: The limits group has 16 bits, where bit n is the limit failure of channel n+1. It has its own filters and enable.
- R10: Status byte bit 6 is the OR of all other status byte bits ANDed with the matching service-request enable bits. Service-request enable bit 6 is ignored.
- R11: `srq` is registered and equals status byte bit 6 in every cycle.
- R12: Clear-status leaves every enable and filter register unchanged.
- R13: A write takes place when `cfg_we` is 1, and `cfg_sel` picks the target: 0 standard enable, 1 service-request enable, 2 operation positive filter, 3 operation negative filter, 4 operation enable, 5 questionable positive filter, 6 questionable negative filter, 7 questionable enable, 8 limits positive filter, 9 limits negative filter, 10 limits enable. Other `cfg_sel` values write nothing. The 8-bit targets take `cfg_wdata[7:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration target select |
| cfg_wdata | input | 16 | Configuration write data |
| clr_status | input | 1 | Clears every event register |
| std_evt | input | 8 | Standard event pulses, one per bit |
| errq_nonempty | input | 1 | Error queue holds entries |
| msg_avail | input | 1 | Output data is waiting |
| oper_cond | input | 16 | Operation condition levels |
| ques_cond | input | 16 | Questionable condition levels |
| lim_cond | input | 16 | Per-channel limit failure levels |
| status_byte | output | 8 | Registered status byte |
| srq | output | 1 | Registered service request |

## Verification
Every cycle, assertions check the following:
- status byte bits 0 and 1 stay 0;
- the error and message flags appear one cycle later;
- no event bit drops without a clear;
- filtered transitions and standard event pulses land in the event register on the next edge;
- unused bits stay empty;
- the write decode raises at most one strobe;
- `srq` matches the masked master summary.

Only the bench scenarios can show the rest:
- the path from a limits channel through the questionable group up to status byte bit 3;
- that clear-status spares the enables and filters;
- that service-request enable bit 6 has no effect;
- the power-on event after reset.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int STB_W   = 8;
  localparam int GRP_W   = 16;
  localparam int STD_W   = 8;
  localparam int SEL_W   = 4;
  localparam int N_CFG   = 11;

  // status byte bit positions (decoded by the host)
  localparam int SB_ERRQ = 2;
  localparam int SB_QUES = 3;
  localparam int SB_MAV  = 4;
  localparam int SB_STD  = 5;
  localparam int SB_MSS  = 6;
  localparam int SB_OPER = 7;

  localparam int STD_PON      = 7;
  localparam int QUES_LIM_BIT = 1;

  localparam logic [STD_W-1:0] STD_VALID  = 8'hBD;
  localparam logic [GRP_W-1:0] OPER_VALID = 16'h0013;
  localparam logic [GRP_W-1:0] QUES_VALID = 16'h000F;
  localparam logic [GRP_W-1:0] LIM_VALID  = 16'hFFFF;

  typedef enum logic [SEL_W-1:0] {
    CFG_STD_EN   = 4'd0,
    CFG_SRE      = 4'd1,
    CFG_OPER_PTR = 4'd2,
    CFG_OPER_NTR = 4'd3,
    CFG_OPER_EN  = 4'd4,
    CFG_QUES_PTR = 4'd5,
    CFG_QUES_NTR = 4'd6,
    CFG_QUES_EN  = 4'd7,
    CFG_LIM_PTR  = 4'd8,
    CFG_LIM_NTR  = 4'd9,
    CFG_LIM_EN   = 4'd10
  } cfg_sel_e;
endpackage

// File: rtl/stat_cfg_decode.sv
module stat_cfg_decode #(
  parameter int SEL_W = 4,
  parameter int N_SEL = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  output logic [N_SEL-1:0] we_vec
);
  for (genvar i = 0; i < N_SEL; i++) begin : g_dec
    assign we_vec[i] = cfg_we && (cfg_sel == SEL_W'(i));
  end

  // R13
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(we_vec));
endmodule

// File: rtl/stat_group.sv
module stat_group #(
  parameter int               W          = 16,
  parameter logic [W-1:0]     VALID_MASK = '1,
  parameter bit               EDGE_MODE  = 1'b1,
  parameter logic [W-1:0]     EVT_INIT   = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] cond_in,
  input  logic         ptr_we,
  input  logic         ntr_we,
  input  logic         en_we,
  input  logic [W-1:0] wdata,
  output logic         summary
);
  logic [W-1:0] evt_q;
  logic [W-1:0] en_q;
  logic [W-1:0] hits;

  if (EDGE_MODE) begin : g_edge
    logic [W-1:0] cond_q;
    logic [W-1:0] ptr_q;
    logic [W-1:0] ntr_q;
    logic [W-1:0] cond_m;
    logic [W-1:0] rise;
    logic [W-1:0] fall;

    assign cond_m = cond_in & VALID_MASK;
    assign rise   = cond_m & ~cond_q;
    assign fall   = ~cond_m & cond_q;
    assign hits   = (rise & ptr_q) | (fall & ntr_q);

    always_ff @(posedge clk) begin
      if (rst) begin
        cond_q <= '0;
        ptr_q  <= '1;
        ntr_q  <= '0;
      end else begin
        cond_q <= cond_m;
        if (ptr_we) ptr_q <= wdata;
        if (ntr_we) ntr_q <= wdata;
      end
    end

    // R5
    rise_latch_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((evt_q & $past(rise & ptr_q)) == $past(rise & ptr_q)));
    // R5
    fall_latch_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((evt_q & $past(fall & ntr_q)) == $past(fall & ntr_q)));
  end else begin : g_pulse
    logic unused_filter_we;
    assign unused_filter_we = ptr_we ^ ntr_we;
    assign hits = cond_in & VALID_MASK;

    // R3
    pulse_latch_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((evt_q & $past(cond_in & VALID_MASK)) == $past(cond_in & VALID_MASK)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q <= EVT_INIT & VALID_MASK;
      en_q  <= '0;
    end else begin
      evt_q <= ((clr ? '0 : evt_q) | hits) & VALID_MASK;
      if (en_we) en_q <= wdata;
    end
  end

  assign summary = |(evt_q & en_q);

  // R6
  evt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((evt_q & $past(evt_q)) == $past(evt_q)));
  // R6
  clr_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && hits == '0) |=> (evt_q == '0));
  // R7
  unused_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_q & ~VALID_MASK) == '0);
endmodule

// File: rtl/stat_byte_core.sv
module stat_byte_core
  import stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             errq_nonempty,
  input  logic             msg_avail,
  input  logic             ques_sum,
  input  logic             std_sum,
  input  logic             oper_sum,
  input  logic             sre_we,
  input  logic [STB_W-1:0] sre_wdata,
  output logic [STB_W-1:0] status_byte,
  output logic             srq
);
  localparam logic [STB_W-1:0] MSS_MASK = ~(STB_W'(1) << SB_MSS);

  logic [STB_W-1:0] sre_q;
  logic [STB_W-1:0] raw_bits;
  logic [STB_W-1:0] next_byte;
  logic             mss;

  always_comb begin
    raw_bits          = '0;
    raw_bits[SB_ERRQ] = errq_nonempty;
    raw_bits[SB_QUES] = ques_sum;
    raw_bits[SB_MAV]  = msg_avail;
    raw_bits[SB_STD]  = std_sum;
    raw_bits[SB_OPER] = oper_sum;
    mss               = |(raw_bits & sre_q & MSS_MASK);
    next_byte         = raw_bits;
    next_byte[SB_MSS] = mss;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sre_q       <= '0;
      status_byte <= '0;
      srq         <= 1'b0;
    end else begin
      if (sre_we) sre_q <= sre_wdata;
      status_byte <= next_byte;
      srq         <= mss;
    end
  end

  // R1
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    status_byte[1:0] == 2'b00);
  // R2
  errq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (status_byte[SB_ERRQ] == $past(errq_nonempty)));
  // R2
  mav_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (status_byte[SB_MAV] == $past(msg_avail)));
  // R10
  mss_mask_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (srq == |(status_byte & $past(sre_q) & MSS_MASK)));
  // R11
  srq_match_chk: assert property (@(posedge clk) disable iff (rst)
    srq == status_byte[SB_MSS]);
endmodule

// File: rtl/stat_byte_top.sv
module stat_byte_top
  import stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [GRP_W-1:0] cfg_wdata,
  input  logic             clr_status,
  input  logic [STD_W-1:0] std_evt,
  input  logic             errq_nonempty,
  input  logic             msg_avail,
  input  logic [GRP_W-1:0] oper_cond,
  input  logic [GRP_W-1:0] ques_cond,
  input  logic [GRP_W-1:0] lim_cond,
  output logic [STB_W-1:0] status_byte,
  output logic             srq
);
  logic [N_CFG-1:0] we_vec;
  logic             std_sum;
  logic             oper_sum;
  logic             ques_sum;
  logic             lim_sum;
  logic [GRP_W-1:0] ques_full;

  stat_cfg_decode #(.SEL_W(SEL_W), .N_SEL(N_CFG)) u_dec (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .we_vec(we_vec)
  );

  stat_group #(
    .W(STD_W), .VALID_MASK(STD_VALID), .EDGE_MODE(1'b0),
    .EVT_INIT(STD_W'(1) << STD_PON)
  ) u_std (
    .clk(clk), .rst(rst), .clr(clr_status), .cond_in(std_evt),
    .ptr_we(1'b0), .ntr_we(1'b0), .en_we(we_vec[CFG_STD_EN]),
    .wdata(cfg_wdata[STD_W-1:0]), .summary(std_sum)
  );

  stat_group #(.W(GRP_W), .VALID_MASK(LIM_VALID), .EDGE_MODE(1'b1)) u_lim (
    .clk(clk), .rst(rst), .clr(clr_status), .cond_in(lim_cond),
    .ptr_we(we_vec[CFG_LIM_PTR]), .ntr_we(we_vec[CFG_LIM_NTR]),
    .en_we(we_vec[CFG_LIM_EN]), .wdata(cfg_wdata), .summary(lim_sum)
  );

  always_comb begin
    ques_full               = ques_cond;
    ques_full[QUES_LIM_BIT] = lim_sum;
  end

  stat_group #(.W(GRP_W), .VALID_MASK(QUES_VALID), .EDGE_MODE(1'b1)) u_ques (
    .clk(clk), .rst(rst), .clr(clr_status), .cond_in(ques_full),
    .ptr_we(we_vec[CFG_QUES_PTR]), .ntr_we(we_vec[CFG_QUES_NTR]),
    .en_we(we_vec[CFG_QUES_EN]), .wdata(cfg_wdata), .summary(ques_sum)
  );

  stat_group #(.W(GRP_W), .VALID_MASK(OPER_VALID), .EDGE_MODE(1'b1)) u_oper (
    .clk(clk), .rst(rst), .clr(clr_status), .cond_in(oper_cond),
    .ptr_we(we_vec[CFG_OPER_PTR]), .ntr_we(we_vec[CFG_OPER_NTR]),
    .en_we(we_vec[CFG_OPER_EN]), .wdata(cfg_wdata), .summary(oper_sum)
  );

  stat_byte_core u_core (
    .clk(clk), .rst(rst), .errq_nonempty(errq_nonempty), .msg_avail(msg_avail),
    .ques_sum(ques_sum), .std_sum(std_sum), .oper_sum(oper_sum),
    .sre_we(we_vec[CFG_SRE]), .sre_wdata(cfg_wdata[STB_W-1:0]),
    .status_byte(status_byte), .srq(srq)
  );
endmodule

// File: tb/tb_stat_byte_top.sv
module tb_stat_byte_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        clr_status = 1'b0;
  logic [7:0]  std_evt = '0;
  logic        errq_nonempty = 1'b0;
  logic        msg_avail = 1'b0;
  logic [15:0] oper_cond = '0;
  logic [15:0] ques_cond = '0;
  logic [15:0] lim_cond = '0;
  logic [7:0]  status_byte;
  logic        srq;
  int checks = 0;
  int errors = 0;

  stat_byte_top dut (.*);

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] sel, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic clear();
    @(negedge clk); clr_status = 1'b1;
    @(negedge clk); clr_status = 1'b0;
    settle();
  endtask

  task automatic pulse_std(input logic [7:0] v, input logic with_clr);
    @(negedge clk); std_evt = v; clr_status = with_clr;
    @(negedge clk); std_evt = '0; clr_status = 1'b0;
    settle();
  endtask

  task automatic base_cfg();
    for (int s = 0; s <= 10; s++)
      wr(s[3:0], (s == 2 || s == 5 || s == 8) ? 16'hFFFF : 16'h0000);
    clear();
  endtask

  task automatic t_reset();
    check("R4 reset status byte", status_byte, 8'h00);
    check("R1 low bits", {6'b0, status_byte[1:0]}, 8'h00);
    wr(4'd0, 16'h0080);
    settle();
    check("R4 power-on event", status_byte, 8'h20);
    clear();
    check("R6 clear power-on", status_byte, 8'h00);
  endtask

  task automatic t_flags();
    base_cfg();
    @(negedge clk); errq_nonempty = 1'b1;
    @(negedge clk);
    check("R2 errq bit", status_byte, 8'h04);
    msg_avail = 1'b1; errq_nonempty = 1'b0;
    @(negedge clk);
    check("R2 mav bit", status_byte, 8'h10);
    msg_avail = 1'b0;
    @(negedge clk);
    check("R2 flags not latched", status_byte, 8'h00);
  endtask

  task automatic t_std();
    base_cfg();
    wr(4'd0, 16'h0042);
    pulse_std(8'h42, 1'b0);
    check("R3 bits 1 and 6 ignored", status_byte, 8'h00);
    wr(4'd0, 16'h0010);
    pulse_std(8'h10, 1'b0);
    check("R3 execution error", status_byte, 8'h20);
    clear();
    check("R6 clear std", status_byte, 8'h00);
    wr(4'd0, 16'h0001);
    pulse_std(8'h01, 1'b1);
    check("R6 event with clear survives", status_byte, 8'h20);
  endtask

  task automatic t_oper();
    base_cfg();
    wr(4'd4, 16'h0002);
    @(negedge clk); oper_cond = 16'h0002; settle();
    check("R5 R7 rise sets oper", status_byte, 8'h80);
    @(negedge clk); oper_cond = 16'h0000; settle();
    check("R6 oper latched", status_byte, 8'h80);
    clear();
    check("R6 oper cleared", status_byte, 8'h00);
    wr(4'd2, 16'h0000); wr(4'd3, 16'h0002);
    @(negedge clk); oper_cond = 16'h0002; settle();
    check("R5 rise filtered out", status_byte, 8'h00);
    @(negedge clk); oper_cond = 16'h0000; settle();
    check("R5 fall sets via NTR", status_byte, 8'h80);
    base_cfg();
    wr(4'd4, 16'hFFFF);
    @(negedge clk); oper_cond = 16'hFFEC; settle();
    check("R7 unused oper bits", status_byte, 8'h00);
    @(negedge clk); oper_cond = 16'h0010; settle();
    check("R7 waiting-for-trigger bit", status_byte, 8'h80);
    @(negedge clk); oper_cond = 16'h0000;
  endtask

  task automatic t_clr_keeps();
    clear();
    check("R12 cleared", status_byte, 8'h00);
    @(negedge clk); oper_cond = 16'h0010; settle();
    check("R12 enable and filter kept", status_byte, 8'h80);
    @(negedge clk); oper_cond = 16'h0000;
  endtask

  task automatic t_ques();
    base_cfg();
    wr(4'd7, 16'h0008);
    @(negedge clk); ques_cond = 16'h0008; settle();
    check("R8 unlocked bit", status_byte, 8'h08);
    @(negedge clk); ques_cond = 16'h0000;
    base_cfg();
    wr(4'd7, 16'h0002);
    @(negedge clk); ques_cond = 16'h0002; settle();
    check("R8 ques_cond bit 1 ignored", status_byte, 8'h00);
    @(negedge clk); ques_cond = 16'h0000;
  endtask

  task automatic t_lim();
    base_cfg();
    wr(4'd7, 16'h0002);
    wr(4'd10, 16'h0100);
    @(negedge clk); lim_cond = 16'h0001; settle();
    check("R9 channel 1 not enabled", status_byte, 8'h00);
    @(negedge clk); lim_cond = 16'h0101; settle();
    check("R9 R8 channel 9 reaches ques", status_byte, 8'h08);
    clear();
    check("R6 clear whole tree", status_byte, 8'h00);
    wr(4'd10, 16'h0001);
    settle();
    check("R9 old channel 1 event cleared", status_byte, 8'h00);
    @(negedge clk); lim_cond = 16'h0000; settle();
  endtask

  task automatic t_sre();
    base_cfg();
    wr(4'd1, 16'h0020);
    wr(4'd0, 16'h0004);
    pulse_std(8'h04, 1'b0);
    check("R10 master summary", status_byte, 8'h60);
    check("R11 srq high", {7'b0, srq}, 8'h01);
    wr(4'd1, 16'h0040);
    settle();
    check("R10 sre bit 6 ignored", status_byte, 8'h20);
    check("R11 srq low", {7'b0, srq}, 8'h00);
    wr(4'd1, 16'h0004);
    @(negedge clk); errq_nonempty = 1'b1; settle();
    check("R10 errq service", status_byte, 8'h64);
    check("R11 srq follows", {7'b0, srq}, 8'h01);
    errq_nonempty = 1'b0;
    wr(4'd15, 16'h00FF);
    settle();
    check("R13 unused select", status_byte, 8'h20);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog (R1..): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_flags();
    t_std();
    t_oper();
    t_clr_keeps();
    t_ques();
    t_lim();
    t_sre();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule